// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Front End

This block is the bus-facing half of a 4K x 8 serial nonvolatile memory. It watches the two bus lines with a fast system clock and finds START and STOP conditions. It shifts in a control byte and answers only when the upper nibble holds the fixed device code 1010 and the next three bits equal its strapped select pins. It then drives acknowledges, takes a two-byte word address, and turns the bus traffic into one-cycle read and write strobes on a plain synchronous memory port. The memory array itself is outside the block. A separate write sequencer owns each programming cycle and reports it back on a busy input.

A write transaction loads the internal word pointer from the two address bytes. Each data byte that follows is handed to the memory port at the pointer, and the pointer then advances. A random read is a write-mode control byte and two address bytes, then a repeated START and a read-mode control byte. A read-mode control byte straight after START returns data from the current pointer. While the master acknowledges, read data keeps streaming from successive addresses, and the pointer wraps at the top of the 4K space. SDA is open-drain and is modelled as a pull-low enable that only moves after a falling SCL edge has been seen.

The controller is one state machine. Its states are: IDLE (ignore the bus until START), CTRL (shift in the control byte), CTRL_ACK, AHI (high address byte), AHI_ACK, ALO (low address byte), ALO_ACK, WDAT (write data byte), WDAT_ACK, RDAT (drive eight read bits), RDAT_ACK (sample the master's acknowledge) and HOLD (silent until START or STOP). The transitions are as follows. START from any state goes to CTRL, and STOP from any state goes to IDLE. CTRL goes to CTRL_ACK on a match while not busy, and to IDLE otherwise. CTRL_ACK goes to RDAT in read mode and to AHI in write mode. AHI goes to AHI_ACK when the forbidden high bits are zero and the block is not busy, and to HOLD otherwise. ALO goes to ALO_ACK, or to HOLD when busy. WDAT goes to WDAT_ACK, or to HOLD when busy. Each of AHI_ACK, ALO_ACK and WDAT_ACK moves on to the next byte state (ALO, WDAT, WDAT) at the falling edge of the ninth clock. RDAT goes to RDAT_ACK after eight bits. RDAT_ACK goes to RDAT when the master acknowledges and to HOLD when it does not.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling SDA while SCL is high is START and restarts control-byte reception from any state. A rising SDA while SCL is high is STOP and returns the block to idle. Bytes are sampled on SCL rising edges, most significant bit first.
- R2: The control byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal sel_pins. Bit 0 set means read and clear means write. A control byte that does not match gets no acknowledge, and the block stays silent until the next START.
- R3: An accepted byte is acknowledged by holding SDA low for the whole high phase of the ninth SCL pulse. SDA is released after that pulse falls.
- R4: In write mode two address bytes follow, high byte first. If any of bits 7..4 of the high byte is set, that byte is not acknowledged, and no later byte is acknowledged or written until START or STOP.
- R5: Each data byte after the address is acknowledged and issued as a single-cycle mem_wr_en at the word pointer, and the pointer then advances by one. A read strobe and a write strobe never occur in the same cycle.
- R6: A random read (write-mode control, two address bytes, repeated START, read-mode control) returns the byte stored at that address, most significant bit first. The memory port has a read latency of one cycle.
- R7: When the master acknowledges a read byte, the next address is returned. The pointer wraps from 0xFFF to 0x000.
- R8: A read-mode control byte directly after START returns the byte at the word pointer, which holds the last accessed address plus one.
- R9: When the master does not acknowledge a read byte, SDA is released and stays released for any further clocks until START or STOP.
- R10: While prog_busy is high, no byte is acknowledged (the control byte included) and no write strobe is issued. This holds also when prog_busy rises just before the ninth SCL pulse.
- R11: sda_pull changes only after a falling SCL edge has been seen, and never while SCL has been high for more than the synchronizer delay.
- R12: After reset, SDA is released and both memory strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Level of the serial clock line |
| sda_in | input | 1 | Level of the serial data line (wired-AND of all drivers) |
| sda_pull | output | 1 | When high, the data line is pulled low |
| sel_pins | input | 3 | Strapped select value compared with control bits 3..1 |
| prog_busy | input | 1 | High while the write sequencer runs a programming cycle |
| mem_addr | output | 12 | Word address for the current memory access |
| mem_rd_en | output | 1 | One-cycle read strobe |
| mem_rd_data | input | 8 | Read data, valid one cycle after mem_rd_en |
| mem_wr_en | output | 1 | One-cycle write strobe handed to the write sequencer |
| mem_wr_data | output | 8 | Data byte for the write strobe |

## Verification
The case that needs care is a data byte completing in the same cycle that the busy input rises. The eighth-bit falling edge is where the block decides both to acknowledge and to issue the write strobe, and a busy signal arriving then must suppress both. The bench provokes this by raising prog_busy during the high phase of the eighth data bit, a few system cycles before that falling edge reaches the controller through the synchronizer. It then expects the ninth-clock acknowledge to be missing, the write count to stay the same and the target memory byte to keep its old value. A normal write issued once busy clears confirms that the block recovered.

// File: rtl/sms_pkg.sv
package sms_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTRL,
        ST_CTRL_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK,
        ST_HOLD
    } sms_state_e;

endpackage

// File: rtl/sms_bus_cond.sv
// Synchronizes both bus lines and derives edge and START/STOP pulses.
module sms_bus_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_cond,
    output logic stop_cond
);

    logic [SYNC_STAGES-1:0] scl_sr;
    logic [SYNC_STAGES-1:0] sda_sr;
    logic                   scl_q;
    logic                   sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sr <= '1;
            sda_sr <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_in};
            sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_in};
            scl_q  <= scl_sr[SYNC_STAGES-1];
            sda_q  <= sda_sr[SYNC_STAGES-1];
        end
    end

    assign scl_lvl    = scl_sr[SYNC_STAGES-1];
    assign sda_lvl    = sda_sr[SYNC_STAGES-1];
    assign scl_rise   = scl_lvl & ~scl_q;
    assign scl_fall   = ~scl_lvl & scl_q;
    // both lines share one synchronizer depth, so their order is kept
    assign start_cond = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_cond  = scl_lvl & scl_q & ~sda_q & sda_lvl;

endmodule

// File: rtl/sms_rx_shift.sv
// Serial-in byte register with a saturating bit counter.
module sms_rx_shift #(
    parameter int BITS = 8,
    parameter int CW   = $clog2(BITS + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [BITS-1:0] data,
    output logic [CW-1:0]   count
);

    localparam logic [CW-1:0] FULL = CW'(BITS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data  <= '0;
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (shift_en) begin
            data <= {data[BITS-2:0], bit_in};
            if (count != FULL) begin
                count <= count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/sms_ctrl.sv
// Transaction state machine: addressing, acknowledges, memory strobes.
module sms_ctrl
    import sms_pkg::*;
#(
    parameter int          ADDR_W   = 12,
    parameter logic [3:0]  DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_cond,
    input  logic              stop_cond,
    input  logic              sda_lvl,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [2:0]        sel_pins,
    input  logic              prog_busy,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              bit_clr,
    output logic              sda_pull,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [BYTE_W-1:0] mem_wr_data,
    output sms_state_e        state_o
);

    localparam int              AHI_BITS = ADDR_W - BYTE_W;
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(BYTE_W);

    sms_state_e            state_q;
    sms_state_e            state_nx;
    logic                  rd_mode_q;
    logic [AHI_BITS-1:0]   ahi_q;
    logic [ADDR_W-1:0]     ptr_q;
    logic [BYTE_W-1:0]     tx_q;
    logic                  rd_pend_q;

    logic byte_done;
    logic ctrl_match;
    logic ahi_ok;
    logic in_ack;

    assign byte_done  = scl_fall && (rx_count == FULL);
    assign ctrl_match = (rx_byte[7:4] == DEV_CODE) && (rx_byte[3:1] == sel_pins);
    assign ahi_ok     = ((rx_byte >> AHI_BITS) == '0);
    assign in_ack     = (state_q == ST_CTRL_ACK) || (state_q == ST_AHI_ACK) ||
                        (state_q == ST_ALO_ACK)  || (state_q == ST_WDAT_ACK) ||
                        (state_q == ST_RDAT_ACK);
    // every falling edge that leaves an ack slot starts a fresh byte
    assign bit_clr    = start_cond || (scl_fall && in_ack);
    assign state_o    = state_q;

    // next-state logic
    always_comb begin
        state_nx = state_q;
        if (start_cond) begin
            state_nx = ST_CTRL;
        end else if (stop_cond) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: state_nx = ST_IDLE;
                ST_HOLD: state_nx = ST_HOLD;
                ST_CTRL: begin
                    if (byte_done) begin
                        state_nx = (ctrl_match && !prog_busy) ? ST_CTRL_ACK : ST_IDLE;
                    end
                end
                ST_CTRL_ACK: begin
                    if (scl_fall) begin
                        state_nx = rd_mode_q ? ST_RDAT : ST_AHI;
                    end
                end
                ST_AHI: begin
                    if (byte_done) begin
                        state_nx = (ahi_ok && !prog_busy) ? ST_AHI_ACK : ST_HOLD;
                    end
                end
                ST_AHI_ACK: if (scl_fall) state_nx = ST_ALO;
                ST_ALO: begin
                    if (byte_done) begin
                        state_nx = prog_busy ? ST_HOLD : ST_ALO_ACK;
                    end
                end
                ST_ALO_ACK: if (scl_fall) state_nx = ST_WDAT;
                ST_WDAT: begin
                    if (byte_done) begin
                        state_nx = prog_busy ? ST_HOLD : ST_WDAT_ACK;
                    end
                end
                ST_WDAT_ACK: if (scl_fall) state_nx = ST_WDAT;
                ST_RDAT: if (byte_done) state_nx = ST_RDAT_ACK;
                ST_RDAT_ACK: begin
                    if (scl_rise && sda_lvl) begin
                        state_nx = ST_HOLD;
                    end else if (scl_fall) begin
                        state_nx = ST_RDAT;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull    <= 1'b0;
            rd_mode_q   <= 1'b0;
            ahi_q       <= '0;
            ptr_q       <= '0;
            tx_q        <= '1;
            rd_pend_q   <= 1'b0;
            mem_addr    <= '0;
            mem_rd_en   <= 1'b0;
            mem_wr_en   <= 1'b0;
            mem_wr_data <= '0;
        end else begin
            mem_rd_en <= 1'b0;
            mem_wr_en <= 1'b0;
            rd_pend_q <= mem_rd_en;
            if (rd_pend_q) begin
                tx_q <= mem_rd_data;
            end
            if (start_cond || stop_cond) begin
                sda_pull <= 1'b0;
            end else begin
                unique case (state_q)
                    ST_CTRL: begin
                        if (byte_done) begin
                            rd_mode_q <= rx_byte[0];
                            if (ctrl_match && !prog_busy) begin
                                sda_pull <= 1'b1;
                                if (rx_byte[0]) begin
                                    mem_rd_en <= 1'b1;
                                    mem_addr  <= ptr_q;
                                    ptr_q     <= ptr_q + 1'b1;
                                end
                            end
                        end
                    end
                    ST_CTRL_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= rd_mode_q ? ~tx_q[7] : 1'b0;
                        end
                    end
                    ST_AHI: begin
                        if (byte_done && ahi_ok && !prog_busy) begin
                            sda_pull <= 1'b1;
                            ahi_q    <= rx_byte[AHI_BITS-1:0];
                        end
                    end
                    ST_ALO: begin
                        if (byte_done && !prog_busy) begin
                            sda_pull <= 1'b1;
                            ptr_q    <= {ahi_q, rx_byte};
                        end
                    end
                    ST_WDAT: begin
                        if (byte_done && !prog_busy) begin
                            sda_pull    <= 1'b1;
                            mem_wr_en   <= 1'b1;
                            mem_addr    <= ptr_q;
                            mem_wr_data <= rx_byte;
                            ptr_q       <= ptr_q + 1'b1;
                        end
                    end
                    ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            sda_pull <= 1'b0;
                        end
                    end
                    ST_RDAT: begin
                        if (scl_fall) begin
                            if (rx_count == FULL) begin
                                sda_pull <= 1'b0;
                            end else begin
                                sda_pull <= ~tx_q[6];
                                tx_q     <= {tx_q[6:0], 1'b1};
                            end
                        end
                    end
                    ST_RDAT_ACK: begin
                        if (scl_rise && !sda_lvl) begin
                            mem_rd_en <= 1'b1;
                            mem_addr  <= ptr_q;
                            ptr_q     <= ptr_q + 1'b1;
                        end else if (scl_fall) begin
                            sda_pull <= ~tx_q[7];
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave
    import sms_pkg::*;
#(
    parameter int         ADDR_W      = 12,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              sda_pull,
    input  logic [2:0]        sel_pins,
    input  logic              prog_busy,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd_en,
    input  logic [BYTE_W-1:0] mem_rd_data,
    output logic              mem_wr_en,
    output logic [BYTE_W-1:0] mem_wr_data
);

    logic              scl_lvl;
    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_cond;
    logic              stop_cond;
    logic              bit_clr;
    logic [BYTE_W-1:0] rx_byte;
    logic [CNT_W-1:0]  rx_count;
    sms_state_e        state_w;

    sms_bus_cond #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_cond (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_in     (scl_in),
        .sda_in     (sda_in),
        .scl_lvl    (scl_lvl),
        .sda_lvl    (sda_lvl),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_cond (start_cond),
        .stop_cond  (stop_cond)
    );

    sms_rx_shift #(
        .BITS (BYTE_W),
        .CW   (CNT_W)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (bit_clr),
        .shift_en (scl_rise),
        .bit_in   (sda_lvl),
        .data     (rx_byte),
        .count    (rx_count)
    );

    sms_ctrl #(
        .ADDR_W   (ADDR_W),
        .DEV_CODE (DEV_CODE)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_cond  (start_cond),
        .stop_cond   (stop_cond),
        .sda_lvl     (sda_lvl),
        .rx_byte     (rx_byte),
        .rx_count    (rx_count),
        .sel_pins    (sel_pins),
        .prog_busy   (prog_busy),
        .mem_rd_data (mem_rd_data),
        .bit_clr     (bit_clr),
        .sda_pull    (sda_pull),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_data (mem_wr_data),
        .state_o     (state_w)
    );

endmodule

// File: rtl/sms_checker.sv
module sms_checker
    import sms_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_cond,
    input logic       stop_cond,
    input sms_state_e state,
    input logic       sda_pull,
    input logic       prog_busy,
    input logic       mem_wr_en,
    input logic       mem_rd_en
);

    assert_start_restarts_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_cond |=> (state == ST_CTRL));

    assert_stop_idles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cond |=> (state == ST_IDLE));

    assert_idle_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_pull);

    assert_wr_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |=> !mem_wr_en);

    assert_no_strobe_overlap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && mem_rd_en));

    assert_hold_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> !sda_pull);

    assert_busy_blocks_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prog_busy) |-> !mem_wr_en);

    assert_pull_steady_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull));

endmodule

bind serial_mem_slave sms_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_lvl    (scl_lvl),
    .start_cond (start_cond),
    .stop_cond  (stop_cond),
    .state      (state_w),
    .sda_pull   (sda_pull),
    .prog_busy  (prog_busy),
    .mem_wr_en  (mem_wr_en),
    .mem_rd_en  (mem_rd_en)
);

// File: tb/tb_serial_mem_slave.sv
`timescale 1ns/1ps
module tb_serial_mem_slave;

    localparam int Q = 10;                 // quarter of an SCL period, in clk cycles
    localparam logic [7:0] CW_OK = 8'hAA;  // 1010, select 101, write
    localparam logic [7:0] CR_OK = 8'hAB;  // 1010, select 101, read

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        prog_busy = 1'b0;
    logic [2:0]  sel_pins = 3'b101;
    logic        sda_pull;
    logic        sda_bus;
    logic [11:0] mem_addr;
    logic        mem_rd_en;
    logic        mem_wr_en;
    logic [7:0]  mem_wr_data;
    logic [7:0]  mem_rd_data;

    logic [7:0]  ram [4096];
    int          wr_count = 0;
    int          checks = 0;
    int          failures = 0;
    int          r11_viol = 0;
    int          scl_hi = 0;
    logic        pull_prev = 1'b0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    assign sda_bus = sda_m & ~sda_pull;

    serial_mem_slave dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_in      (scl_m),
        .sda_in      (sda_bus),
        .sda_pull    (sda_pull),
        .sel_pins    (sel_pins),
        .prog_busy   (prog_busy),
        .mem_addr    (mem_addr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_data (mem_wr_data)
    );

    function automatic logic [7:0] pat(input int a);
        logic [11:0] v;
        v = a[11:0];
        return v[7:0] ^ {v[11:8], v[11:8]} ^ 8'h3C;
    endfunction

    // memory model: one-cycle read latency, preloaded during reset
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) ram[i] <= pat(i);
        end else begin
            if (mem_wr_en) begin
                ram[mem_addr] <= mem_wr_data;
                wr_count <= wr_count + 1;
            end
            if (mem_rd_en) mem_rd_data <= ram[mem_addr];
        end
    end

    // R11 monitor: pull must not move once SCL has been high a while
    always @(posedge clk) begin
        scl_hi <= scl_m ? scl_hi + 1 : 0;
        pull_prev <= sda_pull;
        if (rst_n && scl_hi >= 4 && sda_pull != pull_prev) r11_viol <= r11_viol + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit busy_late, output bit acked);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            if (i == 0 && busy_late) prog_busy = 1'b1;
            scl_m = 1'b0; tick(Q);
        end
        sda_m = 1'b1; tick(Q);
        scl_m = 1'b1; tick(1);
        a1 = !sda_bus; tick(2 * Q - 2);
        a2 = !sda_bus; tick(1);
        scl_m = 1'b0; tick(Q);
        acked = a1 && a2;
    endtask

    task automatic recv_byte(input bit master_ack, output logic [7:0] d);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            d[i] = sda_bus; tick(Q);
            scl_m = 1'b0;
        end
        tick(Q);
        sda_m = !master_ack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        sda_m = 1'b1;
    endtask

    task automatic set_address(input logic [11:0] a);
        bit ack;
        bus_start();
        send_byte(CW_OK, 0, ack); check_eq("R2", "write control ack", ack, 1);
        send_byte({4'h0, a[11:8]}, 0, ack); check_eq("R4", "addr high ack", ack, 1);
        send_byte(a[7:0], 0, ack); check_eq("R4", "addr low ack", ack, 1);
    endtask

    task automatic t_reset();
        check_eq("R12", "sda_pull after reset", sda_pull, 0);
        check_eq("R12", "mem_wr_en after reset", mem_wr_en, 0);
        check_eq("R12", "mem_rd_en after reset", mem_rd_en, 0);
    endtask

    task automatic t_byte_write();
        bit ack;
        int w0;
        w0 = wr_count;
        set_address(12'h123);
        send_byte(8'h5A, 0, ack); check_eq("R3", "data ack held whole high phase", ack, 1);
        bus_stop(); tick(Q);
        check_eq("R5", "byte written at 0x123", ram[12'h123], 8'h5A);
        check_eq("R5", "one write strobe", wr_count - w0, 1);
    endtask

    task automatic t_multi_write();
        bit ack;
        set_address(12'h200);
        send_byte(8'h11, 0, ack); check_eq("R5", "first data ack", ack, 1);
        send_byte(8'h22, 0, ack); check_eq("R5", "second data ack", ack, 1);
        bus_stop(); tick(Q);
        check_eq("R5", "byte at 0x200", ram[12'h200], 8'h11);
        check_eq("R5", "pointer advanced to 0x201", ram[12'h201], 8'h22);
    endtask

    task automatic t_random_read(input logic [11:0] a, input logic [7:0] exp);
        bit ack;
        logic [7:0] d;
        set_address(a);
        bus_start();
        send_byte(CR_OK, 0, ack); check_eq("R6", "read control ack", ack, 1);
        recv_byte(0, d);
        bus_stop();
        check_eq("R6", "random read data", d, exp);
    endtask

    task automatic t_seq_wrap();
        bit ack;
        logic [7:0] d;
        set_address(12'hFFE);
        bus_start();
        send_byte(CR_OK, 0, ack); check_eq("R7", "read control ack", ack, 1);
        recv_byte(1, d); check_eq("R7", "byte at 0xFFE", d, pat(12'hFFE));
        recv_byte(1, d); check_eq("R7", "byte at 0xFFF", d, pat(12'hFFF));
        recv_byte(0, d); check_eq("R7", "wrapped byte at 0x000", d, pat(0));
        bus_stop();
    endtask

    task automatic t_current_read();
        bit ack;
        logic [7:0] d;
        bus_start();
        send_byte(CR_OK, 0, ack); check_eq("R8", "current read control ack", ack, 1);
        recv_byte(0, d); check_eq("R8", "current address byte 0x001", d, pat(1));
        // after the missing acknowledge the slave must stay off the line
        recv_byte(0, d); check_eq("R9", "line released after nack", d, 8'hFF);
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit ack;
        int w0;
        w0 = wr_count;
        bus_start();
        send_byte(8'hA8, 0, ack); check_eq("R2", "wrong select not acked", ack, 0);
        send_byte(8'h00, 0, ack); check_eq("R2", "silent until START", ack, 0);
        bus_stop();
        bus_start();
        send_byte(8'hBA, 0, ack); check_eq("R2", "wrong device code not acked", ack, 0);
        bus_stop(); tick(Q);
        check_eq("R2", "no write after mismatch", wr_count - w0, 0);
    endtask

    task automatic t_addr_high();
        bit ack;
        int w0;
        w0 = wr_count;
        bus_start();
        send_byte(CW_OK, 0, ack); check_eq("R4", "control ack", ack, 1);
        send_byte(8'h10, 0, ack); check_eq("R4", "high bits set not acked", ack, 0);
        send_byte(8'h40, 0, ack); check_eq("R4", "following byte not acked", ack, 0);
        send_byte(8'h99, 0, ack); check_eq("R4", "data not acked", ack, 0);
        bus_stop(); tick(Q);
        check_eq("R4", "no write after bad address", wr_count - w0, 0);
    endtask

    task automatic t_busy();
        bit ack;
        int w0;
        w0 = wr_count;
        prog_busy = 1'b1;
        bus_start();
        send_byte(CW_OK, 0, ack); check_eq("R10", "control not acked while busy", ack, 0);
        bus_stop();
        prog_busy = 1'b0;
        // busy rises as the data byte completes
        set_address(12'h345);
        send_byte(8'hC3, 1, ack); check_eq("R10", "late busy suppresses ack", ack, 0);
        bus_stop(); tick(Q);
        check_eq("R10", "late busy suppresses write", wr_count - w0, 0);
        check_eq("R10", "memory at 0x345 untouched", ram[12'h345], pat(12'h345));
        prog_busy = 1'b0;
        set_address(12'h345);
        send_byte(8'hC3, 0, ack); check_eq("R10", "ack once busy clears", ack, 1);
        bus_stop(); tick(Q);
        check_eq("R10", "write once busy clears", ram[12'h345], 8'hC3);
    endtask

    task automatic t_start_midbyte();
        bit ack;
        bus_start();
        for (int i = 7; i >= 4; i--) begin
            sda_m = CW_OK[i]; tick(Q);
            scl_m = 1'b1; tick(2 * Q);
            scl_m = 1'b0; tick(Q);
        end
        set_address(12'h300);
        send_byte(8'h77, 0, ack); check_eq("R1", "data ack after restart", ack, 1);
        bus_stop(); tick(Q);
        check_eq("R1", "write after mid-byte START", ram[12'h300], 8'h77);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        tick(5);
        t_reset();
        rst_n = 1'b1;
        tick(Q);
        t_byte_write();
        t_multi_write();
        t_random_read(12'h123, 8'h5A);
        t_random_read(12'h7E1, pat(12'h7E1));
        t_seq_wrap();
        t_current_read();
        t_mismatch();
        t_addr_high();
        t_busy();
        t_start_midbyte();
        check_eq("R11", "pull changes during SCL high", r11_viol, 0);
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        #1;
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end

endmodule